// File: doc/BRIEF.md
# Shaded Quad Reorder Buffer

This block sits between a pool of shader units and the blend/depth stage. Shaded quads come back from the shaders in whatever order the shading finishes, since branches, discarded pixels and texture latency all vary. Blending and late depth are read-modify-write operations, so they must see primitives in the order the application submitted them. The buffer restores that order, and it restores only as much of it as correctness needs. Quads of one primitive never overlap, so they may leave in any order among themselves. A quad of a later primitive always waits until every quad of every earlier primitive has left.

The rasterizer reserves an entry for each quad on the allocation port, in submission order, and marks the last quad of each primitive. The entry number goes to the shader with the work. When shading ends, the shader returns the entry number with the quad's tile position, coverage and four colours on the completion port. The completion port never stalls. Backpressure is applied only on the allocation side, when the quad entries or the primitive slots run out. Released quads leave on a valid/ready stream to the blend stage.

Top module: `quad_reorder_buf`

## Requirements
- R1: After rst_n is released the buffer is empty, out_valid is 0 and alloc_ready is 1.
- R2: An accepted allocation (alloc_valid and alloc_ready both 1) takes the lowest-numbered free entry, and that number is shown on alloc_entry in the same cycle. The first quad accepted after reset, or after a quad accepted with alloc_eop=1, opens a new primitive with the identifier alloc_prim. Each later quad joins that primitive until one is accepted with alloc_eop=1.
- R3: No quad of a primitive is presented on the output while any quad of an older primitive is still held, whichever primitive finished shading first.
- R4: When no quad is being held back by the output, the buffer presents the lowest-numbered completed entry of the oldest primitive. A quad whose shading has not completed is never presented. A completion can first be presented in the cycle after cmp_valid.
- R5: The presented quad carries, unchanged, the x, y, mask and colour given at completion, together with the primitive identifier given at allocation.
- R6: alloc_ready is 0 while all 16 quad entries are held.
- R7: alloc_ready is 0 while 8 primitives are held and none of them is still open. While a primitive is open, its further quads are accepted as long as an entry is free.
- R8: While out_valid is 1 and out_ready is 0, the next cycle presents the same quad with the same fields. A quad is removed only in a cycle where out_valid and out_ready are both 1, and its entry is free from the next cycle on.
- R9: A completion that names an entry that is not awaiting shading (free, or already completed) has no effect.
- R10: The oldest primitive retires in the same cycle its last held quad leaves, provided its end marker has been seen, so the next primitive can be presented in the following cycle. If the end marker has not been seen, the primitive stays the oldest even with no quads held, and its later quads keep its identifier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Rasterizer requests an entry for a quad |
| alloc_ready | output | 1 | An entry (and, when needed, a primitive slot) is available |
| alloc_prim | input | 12 | Primitive identifier, used when the quad opens a primitive |
| alloc_eop | input | 1 | Quad is the last one of its primitive |
| alloc_entry | output | 4 | Entry number granted to the quad |
| cmp_valid | input | 1 | Shader returns a finished quad |
| cmp_entry | input | 4 | Entry number of the finished quad |
| cmp_x | input | 2 | Tile x position of the quad |
| cmp_y | input | 2 | Tile y position of the quad |
| cmp_mask | input | 4 | Pixel coverage mask |
| cmp_color | input | 128 | Four 32-bit shaded colours |
| out_valid | output | 1 | A quad is presented to the blend stage |
| out_ready | input | 1 | Blend stage accepts the presented quad |
| out_prim | output | 12 | Primitive identifier of the presented quad |
| out_x | output | 2 | Tile x position of the presented quad |
| out_y | output | 2 | Tile y position of the presented quad |
| out_mask | output | 4 | Coverage mask of the presented quad |
| out_color | output | 128 | Colours of the presented quad |

## Verification
The bench first targets a younger primitive that finishes shading first. A design that orders by completion would let it reach blending too early. It then holds the output stalled while a lower-numbered quad of the same primitive completes. A design that re-selects every cycle would change the presented quad under a stalled handshake. It fills the primitive slots and then the entries, including the case where an open primitive keeps accepting quads after the slots are exhausted. A design that mixes up the two limits would either deadlock the rasterizer or overwrite a live slot. It also drains an open primitive to zero held quads, where a design that retires too early would give its later quads a new identity. Completions aimed at free or already finished entries must leave the presented data untouched.

// File: rtl/qrb_pkg.sv
package qrb_pkg;
  localparam int POS_W  = 2;
  localparam int MASK_W = 4;
  localparam int COL_W  = 32;
  localparam int N_COL  = 4;

  typedef struct packed {
    logic [POS_W-1:0]       x;
    logic [POS_W-1:0]       y;
    logic [MASK_W-1:0]      mask;
    logic [N_COL*COL_W-1:0] color;
  } quad_pay_t;

  typedef enum logic [1:0] {
    ENT_FREE = 2'd0,
    ENT_WAIT = 2'd1,
    ENT_DONE = 2'd2
  } ent_st_e;
endpackage

// File: rtl/qrb_entry_pool.sv
module qrb_entry_pool import qrb_pkg::*; #(
  parameter int N_ENT  = 16,
  parameter int N_SLOT = 8,
  parameter int ENT_W  = $clog2(N_ENT),
  parameter int SLOT_W = $clog2(N_SLOT)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_fire,
  input  logic [SLOT_W-1:0]             alloc_slot,
  input  logic                          cmp_valid,
  input  logic [ENT_W-1:0]              cmp_entry,
  input  quad_pay_t                     cmp_pay,
  input  logic                          rel_fire,
  input  logic [ENT_W-1:0]              rel_idx,
  output logic                          free_avail,
  output logic [ENT_W-1:0]              free_idx,
  output logic [N_ENT-1:0]              done_vec,
  output logic [N_ENT-1:0][SLOT_W-1:0]  slot_of,
  output quad_pay_t [N_ENT-1:0]         pay
);
  logic [N_ENT-1:0] free_vec;
  logic [N_ENT-1:0] wait_vec;

  // lowest-numbered free entry wins the grant
  always_comb begin
    free_avail = |free_vec;
    free_idx   = '0;
    for (int k = N_ENT - 1; k >= 0; k--) begin
      if (free_vec[k]) free_idx = ENT_W'(k);
    end
  end

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    ent_st_e             st_q, st_d;
    logic [SLOT_W-1:0]   slot_q;
    quad_pay_t           pay_q;
    logic                take_alloc, take_cmp, take_rel;

    always_comb begin
      take_rel   = rel_fire && (rel_idx == ENT_W'(i));
      take_alloc = alloc_fire && (free_idx == ENT_W'(i));
      take_cmp   = cmp_valid && (cmp_entry == ENT_W'(i)) && (st_q == ENT_WAIT);
      st_d       = st_q;
      if (take_rel)        st_d = ENT_FREE;
      else if (take_alloc) st_d = ENT_WAIT;
      else if (take_cmp)   st_d = ENT_DONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ENT_FREE;
      else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
      if (take_alloc) slot_q <= alloc_slot;
      if (take_cmp)   pay_q  <= cmp_pay;
    end

    assign free_vec[i] = (st_q == ENT_FREE);
    assign wait_vec[i] = (st_q == ENT_WAIT);
    assign done_vec[i] = (st_q == ENT_DONE);
    assign slot_of[i]  = slot_q;
    assign pay[i]      = pay_q;
  end

  // R9: a completion aimed at an already shaded entry leaves it untouched
  assert_ignore_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && done_vec[cmp_entry] && !(rel_fire && rel_idx == cmp_entry))
      |=> (done_vec[$past(cmp_entry)] && pay[$past(cmp_entry)] == $past(pay[cmp_entry])));

  // R4: only a shaded entry can be released
  assert_release_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_fire |-> done_vec[rel_idx]);

  // R9: a completion to an entry not waiting never makes it shaded
  assert_ignore_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && free_vec[cmp_entry] && !alloc_fire) |=> !done_vec[$past(cmp_entry)]);
endmodule

// File: rtl/qrb_prim_ring.sv
module qrb_prim_ring #(
  parameter int N_SLOT = 8,
  parameter int N_ENT  = 16,
  parameter int PRIM_W = 12,
  parameter int SLOT_W = $clog2(N_SLOT),
  parameter int CNT_W  = $clog2(N_ENT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic [PRIM_W-1:0] alloc_prim,
  input  logic              alloc_eop,
  input  logic              drain,
  output logic              slot_ok,
  output logic [SLOT_W-1:0] alloc_slot,
  output logic [SLOT_W-1:0] head_slot,
  output logic              head_busy,
  output logic [PRIM_W-1:0] head_prim
);
  localparam int USED_W = $clog2(N_SLOT + 1);

  logic [SLOT_W-1:0] head_q, head_d, tail_q, tail_d, open_slot_q, open_slot_d;
  logic [USED_W-1:0] used_q, used_d;
  logic              open_q, open_d;
  logic              opening, retire, head_closed;
  logic [CNT_W-1:0]  head_cnt;

  logic [N_SLOT-1:0][CNT_W-1:0]  cnt_all;
  logic [N_SLOT-1:0][PRIM_W-1:0] pid_all;
  logic [N_SLOT-1:0]             closed_vec, busy_vec;

  function automatic logic [SLOT_W-1:0] wrap_inc(input logic [SLOT_W-1:0] v);
    return (v == SLOT_W'(N_SLOT - 1)) ? '0 : v + 1'b1;
  endfunction

  always_comb begin
    opening     = alloc_fire && !open_q;
    alloc_slot  = open_q ? open_slot_q : tail_q;
    slot_ok     = open_q || (used_q != USED_W'(N_SLOT));
    head_slot   = head_q;
    head_cnt    = cnt_all[head_q];
    head_closed = closed_vec[head_q];
    head_busy   = busy_vec[head_q];
    head_prim   = pid_all[head_q];
    retire      = drain && head_closed && (head_cnt == CNT_W'(1));
    head_d      = retire  ? wrap_inc(head_q) : head_q;
    tail_d      = opening ? wrap_inc(tail_q) : tail_q;
    used_d      = used_q;
    if (opening) used_d = used_d + USED_W'(1);
    if (retire)  used_d = used_d - USED_W'(1);
    open_d      = alloc_fire ? !alloc_eop : open_q;
    open_slot_d = opening ? tail_q : open_slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q      <= '0;
      tail_q      <= '0;
      used_q      <= '0;
      open_q      <= 1'b0;
      open_slot_q <= '0;
    end else begin
      head_q      <= head_d;
      tail_q      <= tail_d;
      used_q      <= used_d;
      open_q      <= open_d;
      open_slot_q <= open_slot_d;
    end
  end

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              cls_q, cls_d, bsy_q, bsy_d;
    logic [PRIM_W-1:0] pid_q;
    logic              mine_open, inc, dec;

    always_comb begin
      mine_open = opening && (tail_q == SLOT_W'(s));
      inc       = alloc_fire && (alloc_slot == SLOT_W'(s));
      dec       = drain && (head_q == SLOT_W'(s));
      cnt_d     = cnt_q;
      cls_d     = cls_q;
      bsy_d     = bsy_q;
      if (mine_open) begin
        cnt_d = CNT_W'(1);
        cls_d = alloc_eop;
        bsy_d = 1'b1;
      end else begin
        if (inc && !dec)      cnt_d = cnt_q + CNT_W'(1);
        else if (dec && !inc) cnt_d = cnt_q - CNT_W'(1);
        if (inc && alloc_eop) cls_d = 1'b1;
        if (retire && head_q == SLOT_W'(s)) begin
          bsy_d = 1'b0;
          cls_d = 1'b0;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        cls_q <= 1'b0;
        bsy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_d;
        cls_q <= cls_d;
        bsy_q <= bsy_d;
      end
    end

    always_ff @(posedge clk) begin
      if (mine_open) pid_q <= alloc_prim;
    end

    assign cnt_all[s]    = cnt_q;
    assign closed_vec[s] = cls_q;
    assign busy_vec[s]   = bsy_q;
    assign pid_all[s]    = pid_q;
  end

  // R7: a new primitive never lands on a slot that is still live
  assert_live_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && !open_q) |-> !busy_vec[tail_q]);

  // R3: draining only happens from a live head with quads outstanding
  assert_drain_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> (head_busy && head_cnt != '0));

  // R10: a closed head never lingers with nothing left to drain
  assert_no_stale_head_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (head_busy && head_closed) |-> (head_cnt != '0));
endmodule

// File: rtl/qrb_release.sv
module qrb_release #(
  parameter int N_ENT  = 16,
  parameter int N_SLOT = 8,
  parameter int ENT_W  = $clog2(N_ENT),
  parameter int SLOT_W = $clog2(N_SLOT)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_ENT-1:0]             done_vec,
  input  logic [N_ENT-1:0][SLOT_W-1:0] slot_of,
  input  logic [SLOT_W-1:0]            head_slot,
  input  logic                         head_busy,
  input  logic                         out_ready,
  output logic                         out_valid,
  output logic [ENT_W-1:0]             rel_idx,
  output logic                         rel_fire
);
  logic             cand_ok;
  logic [ENT_W-1:0] cand_idx;
  logic             lock_q, lock_d;
  logic [ENT_W-1:0] lock_idx_q, lock_idx_d;

  // lowest shaded entry belonging to the oldest primitive
  always_comb begin
    cand_ok  = 1'b0;
    cand_idx = '0;
    for (int k = N_ENT - 1; k >= 0; k--) begin
      if (head_busy && done_vec[k] && slot_of[k] == head_slot) begin
        cand_ok  = 1'b1;
        cand_idx = ENT_W'(k);
      end
    end
    rel_idx    = lock_q ? lock_idx_q : cand_idx;
    out_valid  = lock_q || cand_ok;
    rel_fire   = out_valid && out_ready;
    lock_d     = out_valid && !out_ready;
    lock_idx_d = rel_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= lock_d;
      lock_idx_q <= lock_idx_d;
    end
  end

  // R8: a stalled offer keeps pointing at the same entry
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && rel_idx == $past(rel_idx)));
endmodule

// File: rtl/quad_reorder_buf.sv
module quad_reorder_buf import qrb_pkg::*; #(
  parameter int N_ENT  = 16,
  parameter int N_SLOT = 8,
  parameter int PRIM_W = 12,
  parameter int ENT_W  = $clog2(N_ENT),
  parameter int SLOT_W = $clog2(N_SLOT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_valid,
  output logic                   alloc_ready,
  input  logic [PRIM_W-1:0]      alloc_prim,
  input  logic                   alloc_eop,
  output logic [ENT_W-1:0]       alloc_entry,
  input  logic                   cmp_valid,
  input  logic [ENT_W-1:0]       cmp_entry,
  input  logic [POS_W-1:0]       cmp_x,
  input  logic [POS_W-1:0]       cmp_y,
  input  logic [MASK_W-1:0]      cmp_mask,
  input  logic [N_COL*COL_W-1:0] cmp_color,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PRIM_W-1:0]      out_prim,
  output logic [POS_W-1:0]       out_x,
  output logic [POS_W-1:0]       out_y,
  output logic [MASK_W-1:0]      out_mask,
  output logic [N_COL*COL_W-1:0] out_color
);
  logic                         free_avail, slot_ok, alloc_fire, rel_fire, head_busy;
  logic [SLOT_W-1:0]            alloc_slot, head_slot;
  logic [ENT_W-1:0]             rel_idx;
  logic [N_ENT-1:0]             done_vec;
  logic [N_ENT-1:0][SLOT_W-1:0] slot_of;
  quad_pay_t [N_ENT-1:0]        pay_all;
  quad_pay_t                    cmp_pay, cur;

  always_comb begin
    alloc_ready   = free_avail && slot_ok;
    alloc_fire    = alloc_valid && alloc_ready;
    cmp_pay.x     = cmp_x;
    cmp_pay.y     = cmp_y;
    cmp_pay.mask  = cmp_mask;
    cmp_pay.color = cmp_color;
    cur           = pay_all[rel_idx];
    out_x         = cur.x;
    out_y         = cur.y;
    out_mask      = cur.mask;
    out_color     = cur.color;
  end

  qrb_entry_pool #(.N_ENT(N_ENT), .N_SLOT(N_SLOT)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .alloc_slot(alloc_slot),
    .cmp_valid(cmp_valid), .cmp_entry(cmp_entry), .cmp_pay(cmp_pay),
    .rel_fire(rel_fire), .rel_idx(rel_idx),
    .free_avail(free_avail), .free_idx(alloc_entry),
    .done_vec(done_vec), .slot_of(slot_of), .pay(pay_all)
  );

  qrb_prim_ring #(.N_SLOT(N_SLOT), .N_ENT(N_ENT), .PRIM_W(PRIM_W)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .alloc_prim(alloc_prim), .alloc_eop(alloc_eop),
    .drain(rel_fire),
    .slot_ok(slot_ok), .alloc_slot(alloc_slot),
    .head_slot(head_slot), .head_busy(head_busy), .head_prim(out_prim)
  );

  qrb_release #(.N_ENT(N_ENT), .N_SLOT(N_SLOT)) u_rel (
    .clk(clk), .rst_n(rst_n),
    .done_vec(done_vec), .slot_of(slot_of),
    .head_slot(head_slot), .head_busy(head_busy),
    .out_ready(out_ready),
    .out_valid(out_valid), .rel_idx(rel_idx), .rel_fire(rel_fire)
  );

  // R3: whatever is offered belongs to the oldest live primitive
  assert_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (head_busy && slot_of[rel_idx] == head_slot));

  // R8: a stalled offer keeps its fields
  assert_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_color) && $stable(out_prim) &&
                                   $stable(out_mask) && $stable(out_x) && $stable(out_y)));

  // R6: an allocation is never granted with every entry shaded and waiting
  assert_no_overfill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> ($countones(done_vec) < N_ENT));
endmodule

// File: tb/quad_reorder_buf_bench.sv
module quad_reorder_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 16;
  localparam int NS = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         a_v, a_eop, c_v, o_r;
  logic [11:0]  a_pid;
  logic [3:0]   c_e;
  logic [1:0]   c_x, c_y;
  logic [3:0]   c_m;
  logic [127:0] c_col;
  logic         alloc_ready, out_valid;
  logic [3:0]   alloc_entry;
  logic [11:0]  out_prim;
  logic [1:0]   out_x, out_y;
  logic [3:0]   out_mask;
  logic [127:0] out_color;

  always #(CLK_PERIOD / 2) clk = ~clk;

  quad_reorder_buf u_quad_reorder_buf (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(a_v), .alloc_ready(alloc_ready), .alloc_prim(a_pid),
    .alloc_eop(a_eop), .alloc_entry(alloc_entry),
    .cmp_valid(c_v), .cmp_entry(c_e), .cmp_x(c_x), .cmp_y(c_y),
    .cmp_mask(c_m), .cmp_color(c_col),
    .out_valid(out_valid), .out_ready(o_r), .out_prim(out_prim),
    .out_x(out_x), .out_y(out_y), .out_mask(out_mask), .out_color(out_color)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // behavioural reference model
  typedef struct { int pid; int cnt; bit closed; int seq; } prim_t;
  prim_t        pq[$];
  int           m_st[NE];
  int           m_seq[NE];
  bit [147:0]   m_pay[NE];
  bit           m_open, lk_v;
  int           lk_i, next_seq;
  bit           e_ready, e_valid;
  int           e_entry, e_sel;
  bit [147:0]   e_pay;

  task automatic chk(bit ok, string req, string what, logic [159:0] act, logic [159:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    pq.delete();
    for (int k = 0; k < NE; k++) begin m_st[k] = 0; m_seq[k] = 0; m_pay[k] = '0; end
    m_open = 0; lk_v = 0; lk_i = 0; next_seq = 0;
  endtask

  task automatic eval();
    e_ready = 0; e_entry = 0;
    for (int k = NE - 1; k >= 0; k--) if (m_st[k] == 0) begin e_ready = 1; e_entry = k; end
    e_ready = e_ready && (m_open || pq.size() < NS);
    e_valid = 0; e_sel = 0;
    if (lk_v) begin
      e_valid = 1; e_sel = lk_i;
    end else if (pq.size() > 0) begin
      for (int k = NE - 1; k >= 0; k--)
        if (m_st[k] == 2 && m_seq[k] == pq[0].seq) begin e_valid = 1; e_sel = k; end
    end
    e_pay = '0;
    if (e_valid) e_pay = {12'(pq[0].pid), m_pay[e_sel][135:0]};
  endtask

  task automatic update();
    bit o_fire, a_fire, c_ok;
    o_fire = e_valid && o_r;
    a_fire = a_v && e_ready;
    c_ok   = c_v && (m_st[c_e] == 1);
    lk_v = e_valid && !o_r;
    lk_i = e_sel;
    if (o_fire) begin
      m_st[e_sel] = 0;
      pq[0].cnt = pq[0].cnt - 1;
      if (pq[0].cnt == 0 && pq[0].closed) void'(pq.pop_front());
    end
    if (c_ok) begin
      m_st[c_e] = 2;
      m_pay[c_e] = {12'h0, c_x, c_y, c_m, c_col};
    end
    if (a_fire) begin
      int sq;
      if (!m_open) begin
        prim_t p;
        p.pid = int'(a_pid); p.cnt = 1; p.closed = a_eop; p.seq = next_seq;
        sq = next_seq; next_seq++;
        pq.push_back(p);
      end else begin
        pq[pq.size()-1].cnt = pq[pq.size()-1].cnt + 1;
        if (a_eop) pq[pq.size()-1].closed = 1;
        sq = pq[pq.size()-1].seq;
      end
      m_st[e_entry] = 1;
      m_seq[e_entry] = sq;
      m_open = !a_eop;
    end
  endtask

  // called at a falling edge with inputs already driven
  task automatic tick();
    #1;
    eval();
    chk(alloc_ready == e_ready, "R7", "alloc_ready", 160'(alloc_ready), 160'(e_ready));
    if (e_ready) chk(alloc_entry == 4'(e_entry), "R2", "alloc_entry", 160'(alloc_entry), 160'(e_entry));
    chk(out_valid == e_valid, "R3", "out_valid", 160'(out_valid), 160'(e_valid));
    if (e_valid && out_valid)
      chk({out_prim, out_x, out_y, out_mask, out_color} == e_pay, "R5", "payload",
          160'({out_prim, out_x, out_y, out_mask, out_color}), 160'(e_pay));
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  task automatic idle();
    a_v = 0; a_eop = 0; a_pid = '0; c_v = 0; c_e = '0;
    c_x = '0; c_y = '0; c_m = '0; c_col = '0;
  endtask

  task automatic do_reset();
    idle(); o_r = 0;
    rst_n = 0;
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic alloc_q(int pid, bit eop);
    a_v = 1; a_pid = 12'(pid); a_eop = eop;
    tick();
    a_v = 0; a_eop = 0;
  endtask

  task automatic comp(int e, bit [7:0] sd);
    c_v = 1; c_e = 4'(e);
    c_x = sd[1:0]; c_y = sd[3:2]; c_m = sd[7:4];
    c_col = {4{24'h5a5a00, sd}};
    tick();
    c_v = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: empty after reset
    chk(out_valid == 0, "R1", "out_valid after reset", 160'(out_valid), 160'(0));
    chk(alloc_ready == 1, "R1", "alloc_ready after reset", 160'(alloc_ready), 160'(1));

    // R3 / R4 / R10: younger primitive finishes first and must wait
    o_r = 1;
    alloc_q(10, 0); alloc_q(10, 1); alloc_q(11, 1);
    comp(2, 8'h21);
    chk(out_valid == 0, "R3", "younger quad held back", 160'(out_valid), 160'(0));
    comp(1, 8'h12);
    chk(out_valid == 1 && out_mask == 4'h1, "R4", "entry 1 offered", 160'(out_mask), 160'(1));
    comp(0, 8'h33);
    chk(out_prim == 12'd10 && out_mask == 4'h3, "R4", "entry 0 offered", 160'(out_mask), 160'(3));
    tick();
    chk(out_valid == 1 && out_prim == 12'd11, "R10", "next primitive follows", 160'(out_prim), 160'(11));
    tick();

    // R8 / R9: stalled offer survives a lower completion and a stray one
    do_reset();
    o_r = 0;
    alloc_q(20, 0); alloc_q(20, 0); alloc_q(20, 1);
    comp(2, 8'hA4);
    comp(0, 8'h57);
    chk(out_valid == 1 && out_mask == 4'hA, "R8", "stalled quad kept", 160'(out_mask), 160'(4'hA));
    comp(2, 8'hF0);
    chk(out_mask == 4'hA && out_x == 2'd0, "R9", "repeat completion ignored", 160'(out_mask), 160'(4'hA));
    comp(9, 8'hC0);
    chk(out_mask == 4'hA, "R9", "completion to free entry ignored", 160'(out_mask), 160'(4'hA));
    o_r = 1;
    tick();
    chk(out_valid == 1 && out_mask == 4'h5, "R8", "next quad after accept", 160'(out_mask), 160'(5));
    tick();
    comp(1, 8'h61);
    tick();

    // R7: eight closed primitives exhaust the slots
    do_reset();
    for (int p = 0; p < NS; p++) alloc_q(30 + p, 1);
    chk(alloc_ready == 0, "R7", "slots exhausted", 160'(alloc_ready), 160'(0));

    // R7 / R6 / R10: an open primitive continues after slots are full
    do_reset();
    for (int p = 0; p < NS - 1; p++) alloc_q(50 + p, 1);
    alloc_q(40, 0);
    chk(alloc_ready == 1, "R7", "open primitive still accepted", 160'(alloc_ready), 160'(1));
    for (int q = 0; q < NE - NS; q++) alloc_q(40, 0);
    chk(alloc_ready == 0, "R6", "entries exhausted", 160'(alloc_ready), 160'(0));
    o_r = 1;
    for (int e = NE - 1; e >= 0; e--) comp(e, 8'(e * 7));
    for (int t = 0; t < 20; t++) tick();
    chk(out_valid == 0 && alloc_ready == 1, "R10", "open head drained", 160'(out_valid), 160'(0));
    alloc_q(40, 1);
    comp(0, 8'h99);
    chk(out_valid == 1 && out_prim == 12'd40, "R10", "open primitive keeps identity", 160'(out_prim), 160'(40));
    tick();

    // randomized traffic, compared every cycle against the model
    do_reset();
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int wl[$];
      idle();
      a_v = ($urandom % 2) == 0;
      a_eop = ($urandom % 3) == 0;
      a_pid = 12'($urandom);
      for (int k = 0; k < NE; k++) if (m_st[k] == 1) wl.push_back(k);
      if (($urandom % 4) != 0) begin
        c_v = 1;
        if (wl.size() > 0 && ($urandom % 5) != 0) c_e = 4'(wl[$urandom % wl.size()]);
        else c_e = 4'($urandom);
        c_x = 2'($urandom); c_y = 2'($urandom); c_m = 4'($urandom);
        c_col = {$urandom, $urandom, $urandom, $urandom};
      end
      o_r = ($urandom % 4) != 0;
      tick();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule